// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This block watches the instruction address bus of a CPU and compares it with one programmed breakpoint address. Software programs the address as two bytes and arms the unit through a control byte, all on a simple byte-wide peripheral bus. When the bus carries the armed address, the unit sets an active flag. It then asks the CPU to enter a break at the next instruction boundary.

The CPU reports the final cycle of each instruction with a strobe. A match seen on that cycle is issued at once. A match seen earlier is held until the strobe comes, and it is dropped if software disarms the unit first. When the break is issued, the unit supplies the software-interrupt opcode for the instruction register. It also supplies a one-bit vector choice, so that the CPU fetches either the normal vector pair or the monitor-mode pair. A further output tells the rest of the system whether status flags may be cleared while the break is in force.

Top module: `addr_break_unit`

## Requirements
- R1: After a synchronous reset, both breakpoint bytes and the control byte read as 0x00, `brk_req` is low and `brk_opcode` is 0x00.
- R2: The breakpoint high byte sits at bus address BASE (default 0xFE0C), the low byte at BASE+1 and the control byte at BASE+2. A read shows the register value on `bus_rdata` one clock after the read is presented. `bus_rdata` is 0x00 when no read is under way.
- R3: In the control byte, bit 7 is the enable and is read/write, and bit 6 is the active flag. Bits 5..0 always read 0. Writing 1 to bit 6 does not set the flag. Writing 0 to bit 6 clears it.
- R4: A match requires both bytes of `cpu_addr` to equal the breakpoint bytes. While the enable is 0, no match has any effect: the flag does not set and no break is issued.
- R5: A match in a cycle where `instr_last` is high raises `brk_req` for exactly one clock, starting at the next clock edge.
- R6: A match in a cycle where `instr_last` is low is held. `brk_req` then pulses after the next cycle in which `instr_last` is high.
- R7: If the enable is written to 0 before that boundary cycle, a held match is cancelled and no break is issued.
- R8: The active flag sets at the clock edge after any enabled match. If a software clear and a match fall in the same cycle, the match wins.
- R9: `brk_opcode` is 0x83 in the cycle `brk_req` is high, and 0x00 otherwise.
- R10: `vec_mon` takes the value of `mon_mode` at the edge that issues the break and holds it until the next break. A value of 0 selects vector bytes FFFC/FFFD and a value of 1 selects FEFC/FEFD.
- R11: `clr_allow` is low only while the active flag is set and `clr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Peripheral bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Peripheral bus byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_addr | input | 16 | CPU instruction address bus |
| instr_last | input | 1 | High on the final cycle of an instruction |
| mon_mode | input | 1 | Monitor mode selects the alternate vector pair |
| clr_en | input | 1 | System permission to clear flags during a break |
| brk_req | output | 1 | One-clock break request |
| brk_opcode | output | 8 | Opcode forced into the instruction register |
| vec_mon | output | 1 | Vector pair select captured at break |
| clr_allow | output | 1 | Flag clearing permitted |

## Verification
A read shows its data one clock after it is presented. The active flag, the break pulse, the opcode and the vector select all show the clock edge after the cycle that caused them. Inputs change on the falling edge, and every output is sampled 2 ns after the rising edge that should have updated it. For each break it expects, the driver queues the rising-edge number at which the break is due. The monitor pops the queue on every break it sees. It compares the edge number, the opcode and the vector select, and it treats any break that no entry accounts for as a failure. `clr_allow` follows its inputs within the same cycle and is checked after the flag has settled.

// File: rtl/abu_pkg.sv
package abu_pkg;
  localparam int BYTE_W  = 8;
  localparam int EN_BIT  = 7;
  localparam int ACT_BIT = 6;
  localparam logic [BYTE_W-1:0] SWI_OP = 8'h83;
endpackage

// File: rtl/abu_regs.sv
module abu_regs
  import abu_pkg::*;
#(
  parameter int AW = 16,
  parameter int BAW = 16,
  parameter logic [BAW-1:0] BASE = 16'hFE0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BAW-1:0]    bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              hit,
  output logic [AW-1:0]     bp_addr,
  output logic              en_q,
  output logic              act_q
);
  localparam int NB = AW / BYTE_W;
  localparam logic [BAW-1:0] CTRL_A = BASE + BAW'(NB);

  logic [BYTE_W-1:0] bp_q [NB];
  logic [BYTE_W-1:0] rd_mux;
  logic wr_ctrl;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == CTRL_A);

  generate
    for (genvar k = 0; k < NB; k++) begin : g_flat
      assign bp_addr[k*BYTE_W +: BYTE_W] = bp_q[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) bp_q[i] <= '0;
    end else if (bus_sel && bus_wr) begin
      for (int i = 0; i < NB; i++)
        if (bus_addr == BASE + BAW'(i)) bp_q[NB-1-i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q <= bus_wdata[EN_BIT];
        if (!bus_wdata[ACT_BIT]) act_q <= 1'b0;
      end
      if (hit) act_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NB; i++)
      if (bus_addr == BASE + BAW'(i)) rd_mux = bp_q[NB-1-i];
    if (bus_addr == CTRL_A) begin
      rd_mux = '0;
      rd_mux[EN_BIT]  = en_q;
      rd_mux[ACT_BIT] = act_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= (bus_sel && !bus_wr) ? rd_mux : '0;
  end
endmodule

// File: rtl/abu_match.sv
module abu_match
  import abu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] bp_addr,
  input  logic          en,
  output logic          hit
);
  localparam int NB = AW / BYTE_W;
  logic [NB-1:0] eq;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_cmp
      assign eq[k] = cpu_addr[k*BYTE_W +: BYTE_W] == bp_addr[k*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign hit = en && (&eq);
endmodule

// File: rtl/abu_seq.sv
module abu_seq
  import abu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hit,
  input  logic              instr_last,
  input  logic              mon_mode,
  output logic              brk_req,
  output logic [BYTE_W-1:0] brk_opcode,
  output logic              vec_mon
);
  logic pend_q;
  logic issue;

  assign issue = en && instr_last && (pend_q || hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      brk_req    <= 1'b0;
      brk_opcode <= '0;
      vec_mon    <= 1'b0;
    end else begin
      pend_q     <= en && !instr_last && (pend_q || hit);
      brk_req    <= issue;
      brk_opcode <= issue ? SWI_OP : '0;
      if (issue) vec_mon <= mon_mode;
    end
  end
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
  import abu_pkg::*;
#(
  parameter int AW = 16,
  parameter int BAW = 16,
  parameter logic [BAW-1:0] BASE = 16'hFE0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BAW-1:0]    bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              instr_last,
  input  logic              mon_mode,
  input  logic              clr_en,
  output logic              brk_req,
  output logic [BYTE_W-1:0] brk_opcode,
  output logic              vec_mon,
  output logic              clr_allow
);
  logic [AW-1:0] bp_addr;
  logic en_q, act_q, hit;

  abu_regs #(.AW(AW), .BAW(BAW), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hit(hit), .bp_addr(bp_addr), .en_q(en_q), .act_q(act_q)
  );

  abu_match #(.AW(AW)) u_match (
    .cpu_addr(cpu_addr), .bp_addr(bp_addr), .en(en_q), .hit(hit)
  );

  abu_seq u_seq (
    .clk(clk), .rst(rst), .en(en_q), .hit(hit), .instr_last(instr_last),
    .mon_mode(mon_mode), .brk_req(brk_req), .brk_opcode(brk_opcode),
    .vec_mon(vec_mon)
  );

  assign clr_allow = !act_q || clr_en;
endmodule

// File: rtl/abu_chk.sv
module abu_chk (
  input logic       clk,
  input logic       rst,
  input logic       instr_last,
  input logic       mon_mode,
  input logic       clr_en,
  input logic       brk_req,
  input logic [7:0] brk_opcode,
  input logic       vec_mon,
  input logic       clr_allow,
  input logic       en_q,
  input logic       act_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!brk_req && brk_opcode == 8'h00));
  // R5
  break_on_boundary_chk: assert property (@(posedge clk) disable iff (rst) brk_req |-> $past(instr_last));
  // R9
  swi_opcode_chk: assert property (@(posedge clk) disable iff (rst) brk_req |-> brk_opcode == 8'h83);
  // R8
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst) $rose(act_q) |-> $past(en_q));
  // R10
  vector_select_chk: assert property (@(posedge clk) disable iff (rst) brk_req |-> vec_mon == $past(mon_mode));
  // R11
  clear_gate_chk: assert property (@(posedge clk) disable iff (rst) !clr_allow |-> (act_q && !clr_en));
endmodule

bind addr_break_unit abu_chk u_abu_chk (
  .clk(clk), .rst(rst), .instr_last(instr_last), .mon_mode(mon_mode),
  .clr_en(clr_en), .brk_req(brk_req), .brk_opcode(brk_opcode),
  .vec_mon(vec_mon), .clr_allow(clr_allow), .en_q(en_q), .act_q(act_q)
);

// File: tb/addr_break_unit_bench.sv
`timescale 1ns/1ps
module addr_break_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cpu_addr = 16'h0000;
  logic instr_last = 1'b0, mon_mode = 1'b0, clr_en = 1'b0;
  logic brk_req, vec_mon, clr_allow;
  logic [7:0] brk_opcode;

  int total = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct { int at; bit vec; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  addr_break_unit u_addr_break_unit (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_addr(cpu_addr), .instr_last(instr_last), .mon_mode(mon_mode),
    .clr_en(clr_en), .brk_req(brk_req), .brk_opcode(brk_opcode),
    .vec_mon(vec_mon), .clr_allow(clr_allow)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard of break events, sampled 2 ns after each rising edge.
  always @(posedge clk) begin
    cyc++;
    #2;
    if (!rst) begin
      if (brk_req) begin
        if (q.size() == 0) begin
          check("R4/R7 unexpected break", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R5/R6 break edge", cyc, e.at);
          check("R9 opcode", brk_opcode, 8'h83);
          check("R10 vector select", vec_mon, e.vec);
        end
      end else if (brk_opcode != 8'h00) begin
        check("R9 opcode idle", brk_opcode, 8'h00);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #2;
    check(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic cpu(input logic [15:0] a, input bit last, input bit brk, input bit v);
    @(negedge clk);
    cpu_addr = a; instr_last = last; mon_mode = v;
    if (brk) q.push_back('{at: cyc + 1, vec: v});
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_addr = 16'h0000; instr_last = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: registers reset to zero
    rd(16'hFE0C, 8'h00, "R1 high byte");
    rd(16'hFE0D, 8'h00, "R1 low byte");
    rd(16'hFE0E, 8'h00, "R1 control");
    check("R1 brk_req", brk_req, 0);
    // R2: read back
    wr(16'hFE0C, 8'h12);
    wr(16'hFE0D, 8'h34);
    rd(16'hFE0C, 8'h12, "R2 high byte");
    rd(16'hFE0D, 8'h34, "R2 low byte");
    // R4: enable 0, matching address ignored
    cpu(16'h1234, 1, 0, 0);
    idle();
    rd(16'hFE0E, 8'h00, "R4 flag stays clear when disabled");
    // R3: writing 1s only sets enable
    wr(16'hFE0E, 8'hFF);
    rd(16'hFE0E, 8'h80, "R3 control bits");
    // R5: match on last cycle
    cpu(16'h1234, 1, 1, 0);
    idle();
    rd(16'hFE0E, 8'hC0, "R8 flag set");
    // R11: clear gate
    #1 check("R11 clr_allow low", clr_allow, 0);
    clr_en = 1'b1;
    #1 check("R11 clr_allow high with clr_en", clr_allow, 1);
    clr_en = 1'b0;
    wr(16'hFE0E, 8'h80);
    rd(16'hFE0E, 8'h80, "R3 flag cleared by 0");
    #1 check("R11 clr_allow with flag clear", clr_allow, 1);
    // R4: half matches
    cpu(16'h1299, 1, 0, 0);
    cpu(16'h5634, 1, 0, 0);
    idle();
    rd(16'hFE0E, 8'h80, "R4 partial match ignored");
    // R6: mid-instruction match, issued at boundary, monitor mode
    cpu(16'h1234, 0, 0, 1);
    cpu(16'h1235, 0, 0, 1);
    cpu(16'h1236, 0, 0, 1);
    cpu(16'h1237, 1, 1, 1);
    idle();
    repeat (3) idle();
    check("R10 vec_mon held", vec_mon, 1);
    // R8: software clear and match in the same cycle, match wins
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 16'hFE0E; bus_wdata = 8'h80;
    cpu_addr = 16'h1234; instr_last = 1'b1; mon_mode = 1'b0;
    q.push_back('{at: cyc + 1, vec: 1'b0});
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; cpu_addr = 16'h0000; instr_last = 1'b0;
    rd(16'hFE0E, 8'hC0, "R8 match beats clear");
    // R7: cancel by disabling before boundary
    wr(16'hFE0E, 8'h80);
    cpu(16'h1234, 0, 0, 0);
    idle();
    wr(16'hFE0E, 8'h00);
    cpu(16'h4000, 1, 0, 0);
    idle();
    rd(16'hFE0E, 8'h00, "R7 disabled control");
    repeat (4) idle();
    check("R5/R6 all expected breaks seen", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule